// File: doc/BRIEF.md
# Receiver Sleep Flag and Status Gating

This block sits beside the symbol decoder of a byte-level serial bus receiver. It keeps a sleep flag for the receiver and uses it to decide which receive events reach the status flags seen by software. Software puts the receiver to sleep when it does not need the rest of the current frame, and that includes frames the node sends itself. The receiver wakes again on the next terminating symbol, which is either an end-of-frame or a break. A transmit timeout, a disabled or not-enabled block, and reset also force the receiver to sleep.

While the receiver sleeps, received bytes are not loaded and do not raise receive-full. Which error flags are still reported depends on whether the node is transmitting. If it is idle, every receive-related flag is suppressed. If it is transmitting, only the load, receive-full and overrun are suppressed, so that bus faults during its own transmission stay visible. Status flags are sticky and software clears them one at a time. The symbol decoding, CRC computation and bus waveform are handled elsewhere.

Top module: `rx_sleep_gate`

## Requirements
- R1: After reset, sleep_o is 1 and every status flag (rx_full_o, eod_o, err_o) is 0.
- R2: A one on sleep_req_i sets sleep_o at the next clock edge. Software has no means of clearing it: with the request removed and no terminating symbol, sleep_o stays 1.
- R3: A tx_timeout_i pulse sets sleep_o at the next clock edge.
- R4: While enable_i is 0 or disable_i is 1, sleep_o is held at 1, even when a terminating symbol arrives. After enable_i rises, sleep_o stays 1 until a terminating symbol is seen.
- R5: An eof_sym_i or brk_sym_i pulse clears sleep_o at the next clock edge when no set condition is present.
- R6: When a terminating symbol and a set condition (sleep request, timeout, disable_i high or enable_i low) fall in the same cycle, sleep_o is 1 after that edge.
- R7: While awake, an rx_byte_i pulse drives load_en_o high in the same cycle and sets rx_full_o at the next edge. eod_sym_i sets eod_o at the next edge. err_raw_i bit k sets err_o bit k at the next edge, where bit 0 is overrun, bit 1 is CRC error, bit 2 is invalid frame and bit 3 is invalid bit. Gating uses the sleep_o value of the cycle in which the strobe arrives.
- R8: While asleep and not transmitting, rx_byte_i gives no load_en_o and no rx_full_o, and no error bit and no eod_o is set.
- R9: While asleep and transmitting, load_en_o, rx_full_o and overrun (err_o bit 0) are suppressed, but CRC, invalid-frame and invalid-bit errors and eod_o are still set.
- R10: Status flags are sticky. stat_clr_i bit 0 clears rx_full_o, bit 1 clears eod_o, and bit 2+k clears err_o bit k, at the next edge. When a set and a clear reach the same flag in one cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable control bit |
| disable_i | input | 1 | Block disable control bit |
| tx_timeout_i | input | 1 | Pulse when the transmit-timeout flag becomes set |
| transmitting_i | input | 1 | High while this node is transmitting |
| sleep_req_i | input | 1 | Software write of one to the sleep bit |
| eof_sym_i | input | 1 | End-of-frame symbol strobe |
| brk_sym_i | input | 1 | Break symbol strobe |
| eod_sym_i | input | 1 | End-of-data symbol strobe |
| rx_byte_i | input | 1 | Received-byte strobe |
| err_raw_i | input | 4 | Raw error strobes: overrun, CRC, invalid frame, invalid bit (bits 0..3) |
| stat_clr_i | input | 6 | Software write-zero clears: rx_full, eod, errors 0..3 |
| sleep_o | output | 1 | Receiver sleep flag |
| load_en_o | output | 1 | Load enable for the received-data register |
| rx_full_o | output | 1 | Receive-full flag |
| eod_o | output | 1 | End-of-data flag |
| err_o | output | 4 | Gated sticky error flags, same bit order as err_raw_i |

## Verification
The assertions assume that every symbol, byte, error and timeout strobe lasts exactly one clock and is synchronous to clk. They also assume that software clears arrive as single-cycle strobes, and that transmitting_i is stable for the cycle in which it qualifies an error. The directed stimulus changes every input shortly after a rising edge and drops each strobe again after a single edge. It holds transmitting_i level for the whole of each gating scenario, so every property sees the input pattern it was written for.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   // error strobe positions; the status bank appends them after two data flags
   localparam int ERR_W   = 4;
   localparam int E_OVR   = 0;
   localparam int E_CRC   = 1;
   localparam int E_FRM   = 2;
   localparam int E_BIT   = 3;
   localparam int S_FULL  = 0;
   localparam int S_EOD   = 1;
   localparam int S_ERR0  = 2;
   localparam int STAT_W  = S_ERR0 + ERR_W;
endpackage

// File: rtl/rsg_sleep_ctl.sv
module rsg_sleep_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic disable_i,
   input  logic tmo_i,
   input  logic sw_set_i,
   input  logic eof_i,
   input  logic brk_i,
   output logic sleep_o
);
   logic force_c, set_c, wake_c, sleep_q;

   // any set source outranks a terminating symbol
   assign force_c = ~enable_i | disable_i;
   assign set_c   = force_c | tmo_i | sw_set_i;
   assign wake_c  = eof_i | brk_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sleep_q <= 1'b1;
      else if (set_c)  sleep_q <= 1'b1;
      else if (wake_c) sleep_q <= 1'b0;
   end

   assign sleep_o = sleep_q;

   // R2
   sw_sets_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_set_i |=> sleep_o);
   // R3
   timeout_sets_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_i |=> sleep_o);
   // R4
   forced_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_i || disable_i) |=> sleep_o);
   // R5
   symbol_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((eof_i || brk_i) && enable_i && !disable_i && !tmo_i && !sw_set_i) |=> !sleep_o);
   // R2
   no_spurious_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && !eof_i && !brk_i) |=> sleep_o);
endmodule

// File: rtl/rsg_event_gate.sv
module rsg_event_gate
   import rsg_pkg::*;
#(
   parameter bit EOD_ON_TX = 1'b1  // report end-of-data while asleep but transmitting
) (
   input  logic              sleep_i,
   input  logic              tx_i,
   input  logic              rx_byte_i,
   input  logic              eod_i,
   input  logic [ERR_W-1:0]  err_i,
   output logic              load_o,
   output logic [STAT_W-1:0] set_o
);
   logic pass_data, pass_bus;

   // data path needs a fully awake receiver; bus faults also pass during own transmit
   assign pass_data = ~sleep_i;
   assign pass_bus  = ~sleep_i | tx_i;

   assign load_o        = rx_byte_i & pass_data;
   assign set_o[S_FULL] = rx_byte_i & pass_data;

   generate
      if (EOD_ON_TX) begin : g_eod_bus
         assign set_o[S_EOD] = eod_i & pass_bus;
      end else begin : g_eod_data
         assign set_o[S_EOD] = eod_i & pass_data;
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < ERR_W; k++) begin : g_err
         if (k == E_OVR) begin : g_ovr
            assign set_o[S_ERR0+k] = err_i[k] & pass_data;
         end else begin : g_bus
            assign set_o[S_ERR0+k] = err_i[k] & pass_bus;
         end
      end
   endgenerate
endmodule

// File: rtl/rsg_sticky_bank.sv
module rsg_sticky_bank #(
   parameter int W        = 6,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("rsg_sticky_bank: W must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         logic q;
         if (SET_WINS) begin : g_set_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        q <= 1'b0;
               else if (set_i[i]) q <= 1'b1;
               else if (clr_i[i]) q <= 1'b0;
            end
         end else begin : g_clr_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        q <= 1'b0;
               else if (clr_i[i]) q <= 1'b0;
               else if (set_i[i]) q <= 1'b1;
            end
         end
         assign q_o[i] = q;

         // R10
         sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q && !clr_i[i]) |=> q);
         // R10
         clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q);
      end
   endgenerate
endmodule

// File: rtl/rx_sleep_gate.sv
module rx_sleep_gate
   import rsg_pkg::*;
#(
   parameter int ERR_BITS  = 4,
   parameter bit EOD_ON_TX = 1'b1,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable_i,
   input  logic                disable_i,
   input  logic                tx_timeout_i,
   input  logic                transmitting_i,
   input  logic                sleep_req_i,
   input  logic                eof_sym_i,
   input  logic                brk_sym_i,
   input  logic                eod_sym_i,
   input  logic                rx_byte_i,
   input  logic [ERR_BITS-1:0] err_raw_i,
   input  logic [ERR_BITS+1:0] stat_clr_i,
   output logic                sleep_o,
   output logic                load_en_o,
   output logic                rx_full_o,
   output logic                eod_o,
   output logic [ERR_BITS-1:0] err_o
);
   localparam int SW = ERR_BITS + 2;

   generate
      if (ERR_BITS != ERR_W) begin : g_bad_err
         $error("rx_sleep_gate: ERR_BITS must match the package error count");
      end
   endgenerate

   logic          sleep_w;
   logic [SW-1:0] set_w;
   logic [SW-1:0] flags_w;

   rsg_sleep_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable_i),
      .disable_i(disable_i),
      .tmo_i    (tx_timeout_i),
      .sw_set_i (sleep_req_i),
      .eof_i    (eof_sym_i),
      .brk_i    (brk_sym_i),
      .sleep_o  (sleep_w)
   );

   rsg_event_gate #(.EOD_ON_TX(EOD_ON_TX)) u_gate (
      .sleep_i  (sleep_w),
      .tx_i     (transmitting_i),
      .rx_byte_i(rx_byte_i),
      .eod_i    (eod_sym_i),
      .err_i    (err_raw_i),
      .load_o   (load_en_o),
      .set_o    (set_w)
   );

   rsg_sticky_bank #(.W(SW), .SET_WINS(SET_WINS)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_w),
      .clr_i(stat_clr_i),
      .q_o  (flags_w)
   );

   assign sleep_o   = sleep_w;
   assign rx_full_o = flags_w[S_FULL];
   assign eod_o     = flags_w[S_EOD];
   assign err_o     = flags_w[SW-1:S_ERR0];

   // R8
   asleep_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && !rx_full_o) |=> !rx_full_o);
   // R8
   asleep_idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && !transmitting_i && err_o == '0 && !eod_o) |=> (err_o == '0 && !eod_o));
   // R9
   asleep_tx_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && !err_o[E_OVR]) |=> !err_o[E_OVR]);
   // R9
   asleep_tx_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && transmitting_i && err_raw_i[E_CRC]) |=> err_o[E_CRC]);
   // R7
   awake_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_o && rx_byte_i) |=> rx_full_o);
endmodule

// File: tb/rx_sleep_gate_test.sv
`timescale 1ns/1ps
module rx_sleep_gate_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable_i = 1'b0, disable_i = 1'b0, tx_timeout_i = 1'b0;
   logic       transmitting_i = 1'b0, sleep_req_i = 1'b0;
   logic       eof_sym_i = 1'b0, brk_sym_i = 1'b0, eod_sym_i = 1'b0, rx_byte_i = 1'b0;
   logic [3:0] err_raw_i = '0;
   logic [5:0] stat_clr_i = '0;
   logic       sleep_o, load_en_o, rx_full_o, eod_o;
   logic [3:0] err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rx_sleep_gate uut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .disable_i(disable_i),
      .tx_timeout_i(tx_timeout_i), .transmitting_i(transmitting_i),
      .sleep_req_i(sleep_req_i), .eof_sym_i(eof_sym_i), .brk_sym_i(brk_sym_i),
      .eod_sym_i(eod_sym_i), .rx_byte_i(rx_byte_i), .err_raw_i(err_raw_i),
      .stat_clr_i(stat_clr_i), .sleep_o(sleep_o), .load_en_o(load_en_o),
      .rx_full_o(rx_full_o), .eod_o(eod_o), .err_o(err_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic drop_strobes();
      sleep_req_i = 0; tx_timeout_i = 0; eof_sym_i = 0; brk_sym_i = 0;
      eod_sym_i = 0; rx_byte_i = 0; err_raw_i = '0; stat_clr_i = '0;
   endtask

   task automatic clear_all();
      stat_clr_i = '1; tick(); drop_strobes();
   endtask

   task automatic t_reset();
      chk("R1 sleep", sleep_o, 1);
      chk("R1 flags", {rx_full_o, eod_o, err_o}, 0);
   endtask

   task automatic t_enable_wake();
      enable_i = 1; tick(); tick();
      chk("R4 stays asleep after enable", sleep_o, 1);
      eof_sym_i = 1; tick(); drop_strobes();
      chk("R5 eof wakes", sleep_o, 0);
   endtask

   task automatic t_awake_events();
      rx_byte_i = 1; #1;
      chk("R7 load same cycle", load_en_o, 1);
      tick(); drop_strobes();
      chk("R7 rx_full", rx_full_o, 1);
      eod_sym_i = 1; err_raw_i = 4'b1111; tick(); drop_strobes();
      chk("R7 eod", eod_o, 1);
      chk("R7 errors", err_o, 4'b1111);
      stat_clr_i = 6'b000100; tick(); drop_strobes();
      chk("R10 overrun cleared", err_o, 4'b1110);
      chk("R10 others kept", {rx_full_o, eod_o}, 2'b11);
      err_raw_i = 4'b0010; stat_clr_i = 6'b001000; tick(); drop_strobes();
      chk("R10 set beats clear", err_o[1], 1);
      clear_all();
      chk("R10 all cleared", {rx_full_o, eod_o, err_o}, 0);
   endtask

   task automatic t_sw_sleep();
      sleep_req_i = 1; tick(); drop_strobes();
      chk("R2 request sets", sleep_o, 1);
      repeat (4) tick();
      chk("R2 no software clear", sleep_o, 1);
   endtask

   task automatic t_asleep_idle();
      transmitting_i = 0;
      rx_byte_i = 1; eod_sym_i = 1; err_raw_i = 4'b1111; #1;
      chk("R8 no load", load_en_o, 0);
      tick(); drop_strobes();
      chk("R8 no flags", {rx_full_o, eod_o, err_o}, 0);
   endtask

   task automatic t_asleep_tx();
      transmitting_i = 1;
      rx_byte_i = 1; eod_sym_i = 1; err_raw_i = 4'b1111; #1;
      chk("R9 no load", load_en_o, 0);
      tick(); drop_strobes();
      chk("R9 rx_full", rx_full_o, 0);
      chk("R9 errors", err_o, 4'b1110);
      chk("R9 eod", eod_o, 1);
      transmitting_i = 0;
      clear_all();
   endtask

   task automatic t_brk_timeout();
      brk_sym_i = 1; tick(); drop_strobes();
      chk("R5 break wakes", sleep_o, 0);
      tx_timeout_i = 1; tick(); drop_strobes();
      chk("R3 timeout sets", sleep_o, 1);
   endtask

   task automatic t_priority();
      eof_sym_i = 1; disable_i = 1; tick(); drop_strobes();
      chk("R6 disable beats eof", sleep_o, 1);
      brk_sym_i = 1; tick(); drop_strobes();
      chk("R4 disable holds sleep", sleep_o, 1);
      disable_i = 0; enable_i = 0;
      eof_sym_i = 1; tick(); drop_strobes();
      chk("R4 enable low holds sleep", sleep_o, 1);
      enable_i = 1;
      brk_sym_i = 1; tick(); drop_strobes();
      chk("R5 wake after enable", sleep_o, 0);
      eof_sym_i = 1; sleep_req_i = 1; tick(); drop_strobes();
      chk("R6 request beats eof", sleep_o, 1);
      brk_sym_i = 1; tick(); drop_strobes();
      tx_timeout_i = 1; brk_sym_i = 1; tick(); drop_strobes();
      chk("R6 timeout beats break", sleep_o, 1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1; tick();
      t_reset();
      t_enable_wake();
      t_awake_events();
      t_sw_sleep();
      t_asleep_idle();
      t_asleep_tx();
      t_brk_timeout();
      t_priority();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule